// File: doc/BRIEF.md
# Watermark Write-Drain Controller

This block arbitrates one shared memory data bus between read requests and a buffer of pending writes. Reads come straight from a valid/ready request port and normally win the bus. Writes are accepted into an internal first-in first-out store and are held back. They are sent as a burst once enough of them have piled up. The burst starts when the stored count reaches a high mark. It keeps issuing writes on consecutive cycles until the count falls to a low mark. The controller then goes back to serving reads.

Turning the bus around from read to write, or from write to read, costs a fixed number of idle cycles, and the controller inserts that penalty only when the issued direction really changes. When no read is waiting and the controller is not draining, a stored write may go out on its own. When the store is full, new writes are refused. The issue port carries one command per cycle with a flag that tells reads from writes, and the fill level of the store is always visible.

Top module: `wdrain_ctrl`

## Requirements
- R1: After reset the store is empty (`occupancy` = 0), `wr_ready` is 1, nothing is issued, the bus direction is read, and the block is not draining.
- R2: When the bus direction is read, no turnaround is pending, the block is not draining and `rd_valid` is 1, a read is issued in that same cycle: `iss_valid`=1, `iss_write`=0, `iss_data`=`rd_addr` and `rd_ready`=1. `rd_ready` is never 1 without such an issue.
- R3: Outside a drain, no write is issued in a cycle where `rd_valid` is 1.
- R4: In the cycle in which `occupancy` has reached `HI_MARK`, the block starts a drain. During the drain reads get no service and writes are issued on every cycle that is not a turnaround cycle.
- R5: A drain goes on while `occupancy` is above `LO_MARK`, including values below `HI_MARK`. It ends once the count equals `LO_MARK`, and read service then resumes.
- R6: Outside a drain, with `rd_valid` at 0 and the store not empty, a stored write is issued.
- R7: Each change of the issued direction is preceded by exactly `TURN` cycles with `iss_valid`=0. Commands in an unchanged direction go out on consecutive cycles with no gap.
- R8: Writes leave in the order they were accepted, and the stored data appears on `iss_data` with `iss_write`=1.
- R9: `occupancy` rises by one for each accepted write (`wr_valid` and `wr_ready` both 1), falls by one for each issued write, and holds in every other cycle.
- R10: When `occupancy` equals `DEPTH`, `wr_ready` is 0 and a write offered in that cycle is dropped without changing the store. A full store always drains, because `HI_MARK` is no greater than `DEPTH`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| wr_valid | input | 1 | A write is offered for the store |
| wr_ready | output | 1 | The store can take a write this cycle |
| wr_data | input | DW | Payload of the offered write |
| rd_valid | input | 1 | A read request is pending |
| rd_ready | output | 1 | The pending read is issued this cycle |
| rd_addr | input | DW | Payload of the pending read |
| iss_valid | output | 1 | A command is placed on the bus this cycle |
| iss_write | output | 1 | 1 marks the issued command as a write, 0 as a read |
| iss_data | output | DW | Payload of the issued command |
| occupancy | output | $clog2(DEPTH+1) | Number of writes held in the store |

## Verification
The bench times the turnaround gap on both kinds of change: from read to write on an opportunistic write, and from write to read after a drain. A design that counted the penalty one cycle off, or charged it on every command, would issue a command too early or leave a gap between commands in the same direction. It holds reads pending all through a fill past the high mark and checks that the drain stops at the low mark and not on the way down past the high mark. A design without hysteresis would give the bus back after a single write. It also fills the store to the top during a turnaround and offers one more write. If that write were taken, the drain would end one write later and the final count would be off by one.

// File: rtl/wdrain_ctrl.sv
module wdrain_ctrl #(
  parameter int DW      = 8,
  parameter int DEPTH   = 8,
  parameter int HI_MARK = 6,
  parameter int LO_MARK = 2,
  parameter int TURN    = 3
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic                         wr_valid,
  output logic                         wr_ready,
  input  logic [DW-1:0]                wr_data,
  input  logic                         rd_valid,
  output logic                         rd_ready,
  input  logic [DW-1:0]                rd_addr,
  output logic                         iss_valid,
  output logic                         iss_write,
  output logic [DW-1:0]                iss_data,
  output logic [$clog2(DEPTH+1)-1:0]   occupancy
);

  localparam int CW = $clog2(DEPTH + 1);
  localparam int PW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int TW = (TURN > 0) ? $clog2(TURN + 1) : 1;
  localparam int TL = (TURN > 0) ? TURN - 1 : 0;
  localparam logic [TW-1:0] TURN_LOAD = TL[TW-1:0];
  localparam logic [PW-1:0] PTR_LAST  = PW'(DEPTH - 1);
  localparam logic [CW-1:0] HI_C      = CW'(HI_MARK);
  localparam logic [CW-1:0] LO_C      = CW'(LO_MARK);
  localparam logic [CW-1:0] FULL_C    = CW'(DEPTH);

  logic [DW-1:0] mem [DEPTH];
  logic [PW-1:0] head_q, tail_q;
  logic [CW-1:0] occ_q, occ_nxt;
  logic [TW-1:0] turn_q;
  logic          dir_wr_q;
  logic          drain_q, drain_nxt;

  logic want_wr, want_rd, want_any, flip, busy, go, enq, deq;

  assign wr_ready = (occ_q != FULL_C);
  assign enq      = wr_valid && wr_ready;
  assign busy     = (turn_q != '0);

  assign want_wr  = (occ_q != '0) && (drain_q || !rd_valid);
  assign want_rd  = rd_valid && !drain_q;
  assign want_any = want_wr || want_rd;
  assign flip     = want_any && (want_wr != dir_wr_q);
  assign go       = want_any && !busy && (!flip || TURN == 0);
  assign deq      = go && want_wr;

  assign iss_valid = go;
  assign iss_write = deq;
  assign iss_data  = want_wr ? mem[head_q] : rd_addr;
  assign rd_ready  = go && !want_wr;
  assign occupancy = occ_q;

  assign occ_nxt   = occ_q + CW'(enq) - CW'(deq);
  assign drain_nxt = drain_q ? (occ_nxt > LO_C) : (occ_nxt >= HI_C);

  always_ff @(posedge clk) begin
    if (enq) mem[tail_q] <= wr_data;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      head_q  <= '0;
      tail_q  <= '0;
      occ_q   <= '0;
      drain_q <= 1'b0;
    end else begin
      occ_q   <= occ_nxt;
      drain_q <= drain_nxt;
      if (enq) tail_q <= (tail_q == PTR_LAST) ? '0 : tail_q + 1'b1;
      if (deq) head_q <= (head_q == PTR_LAST) ? '0 : head_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dir_wr_q <= 1'b0;
      turn_q   <= '0;
    end else if (busy) begin
      turn_q <= turn_q - 1'b1;
    end else if (flip) begin
      dir_wr_q <= want_wr;
      turn_q   <= TURN_LOAD;
    end
  end

endmodule

// File: rtl/wdrain_ctrl_chk.sv
module wdrain_ctrl_chk #(
  parameter int DEPTH   = 8,
  parameter int HI_MARK = 6,
  parameter int LO_MARK = 2,
  parameter int TURN    = 3
) (
  input logic                       clk,
  input logic                       rst_n,
  input logic                       wr_valid,
  input logic                       wr_ready,
  input logic                       rd_valid,
  input logic                       rd_ready,
  input logic                       iss_valid,
  input logic                       iss_write,
  input logic [$clog2(DEPTH+1)-1:0] occupancy,
  input logic                       drain_q
);

  logic started;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) started <= 1'b0;
    else        started <= 1'b1;
  end

  AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
    int'(occupancy) <= DEPTH); // R10

  AST_FULL_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (int'(occupancy) == DEPTH && !(iss_valid && iss_write)) |=> int'(occupancy) == DEPTH); // R10

  AST_OCC_UP: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_valid && wr_ready && !(iss_valid && iss_write)) |=> int'(occupancy) == int'($past(occupancy)) + 1); // R9

  AST_OCC_STILL: assert property (@(posedge clk) disable iff (!rst_n)
    (!(wr_valid && wr_ready) && !(iss_valid && iss_write)) |=> $stable(occupancy)); // R9

  AST_RD_HANDSHAKE: assert property (@(posedge clk) disable iff (!rst_n)
    rd_ready |-> (rd_valid && iss_valid && !iss_write)); // R2

  AST_NO_EMPTY_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    (iss_valid && iss_write) |-> occupancy != '0); // R8

  AST_READ_FIRST: assert property (@(posedge clk) disable iff (!rst_n)
    (iss_valid && iss_write && rd_valid) |-> drain_q); // R3

  AST_DRAIN_NO_READ: assert property (@(posedge clk) disable iff (!rst_n)
    drain_q |-> !rd_ready); // R4

  AST_DRAIN_ABOVE_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    drain_q |-> int'(occupancy) > LO_MARK); // R5

  generate
    if (TURN > 0) begin : g_gap
      AST_TURN_GAP: assert property (@(posedge clk) disable iff (!rst_n)
        (started && iss_valid && $past(iss_valid)) |-> iss_write == $past(iss_write)); // R7
    end
  endgenerate

endmodule

bind wdrain_ctrl wdrain_ctrl_chk #(
  .DEPTH(DEPTH), .HI_MARK(HI_MARK), .LO_MARK(LO_MARK), .TURN(TURN)
) u_chk (
  .clk(clk), .rst_n(rst_n), .wr_valid(wr_valid), .wr_ready(wr_ready),
  .rd_valid(rd_valid), .rd_ready(rd_ready), .iss_valid(iss_valid),
  .iss_write(iss_write), .occupancy(occupancy), .drain_q(drain_q)
);

// File: tb/sim_wdrain_ctrl.sv
module sim_wdrain_ctrl;
  localparam int DW = 8, DEPTH = 8, HI = 6, LO = 2, TURN = 3;
  localparam int CW = $clog2(DEPTH + 1);

  logic clk = 1'b0, rst_n = 1'b0;
  logic wr_valid = 1'b0, rd_valid = 1'b0;
  logic [DW-1:0] wr_data = '0, rd_addr = '0;
  logic wr_ready, rd_ready, iss_valid, iss_write;
  logic [DW-1:0] iss_data;
  logic [CW-1:0] occupancy;
  int checks = 0, fails = 0;

  always #5 clk = ~clk;

  wdrain_ctrl #(.DW(DW), .DEPTH(DEPTH), .HI_MARK(HI), .LO_MARK(LO), .TURN(TURN)) u0 (
    .clk(clk), .rst_n(rst_n), .wr_valid(wr_valid), .wr_ready(wr_ready), .wr_data(wr_data),
    .rd_valid(rd_valid), .rd_ready(rd_ready), .rd_addr(rd_addr), .iss_valid(iss_valid),
    .iss_write(iss_write), .iss_data(iss_data), .occupancy(occupancy));

  task automatic chk(input string req, input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  task automatic step(input bit wv, input int wd, input bit rv, input int ra);
    @(negedge clk);
    wr_valid = wv; wr_data = DW'(wd); rd_valid = rv; rd_addr = DW'(ra);
    #4;
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0; wr_valid = 1'b0; rd_valid = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
  endtask

  task automatic t_reset();
    do_reset();
    step(0, 0, 0, 0);
    chk("R1", "iss_valid", int'(iss_valid), 0);
    chk("R1", "occupancy", int'(occupancy), 0);
    chk("R1", "wr_ready", int'(wr_ready), 1);
    chk("R1", "rd_ready", int'(rd_ready), 0);
  endtask

  task automatic t_reads();
    do_reset();
    for (int i = 0; i < 4; i++) begin
      step(0, 0, 1, 8'h30 + i);
      chk("R2", "read issued", int'(iss_valid && !iss_write && rd_ready), 1);
      chk("R2", "read payload", int'(iss_data), 8'h30 + i);
    end
  endtask

  task automatic t_opportunistic();
    do_reset();
    step(1, 8'h11, 0, 0);
    chk("R6", "nothing yet", int'(iss_valid), 0);
    for (int k = 0; k < TURN; k++) begin
      step(0, 0, 0, 0);
      chk("R7", "idle read->write", int'(iss_valid), 0);
    end
    step(0, 0, 0, 0);
    chk("R6", "write issued", int'(iss_valid && iss_write), 1);
    chk("R8", "write payload", int'(iss_data), 8'h11);
    step(0, 0, 0, 0);
    chk("R9", "occupancy after write", int'(occupancy), 0);
    for (int k = 0; k < TURN; k++) begin
      step(0, 0, 1, 8'h55);
      chk("R7", "idle write->read", int'(iss_valid || rd_ready), 0);
    end
    step(0, 0, 1, 8'h55);
    chk("R7", "read after turn", int'(rd_ready), 1);
    chk("R2", "read payload", int'(iss_data), 8'h55);
  endtask

  task automatic t_drain();
    do_reset();
    for (int i = 0; i < HI - 1; i++) begin
      step(1, 8'hA0 + i, 1, 8'h40 + i);
      chk("R3", "read wins", int'(iss_valid && !iss_write), 1);
      chk("R9", "occupancy rising", int'(occupancy), i);
    end
    for (int i = 0; i < 4; i++) begin
      step(0, 0, 1, 8'h50);
      chk("R3", "writes held", int'(iss_valid && !iss_write), 1);
      chk("R9", "occupancy held", int'(occupancy), HI - 1);
    end
    step(1, 8'hA0 + HI - 1, 1, 8'h51);
    chk("R3", "last read before drain", int'(rd_ready), 1);
    for (int k = 0; k < TURN; k++) begin
      step(0, 0, 1, 8'h52);
      chk("R4", "drain turnaround idle", int'(iss_valid || rd_ready), 0);
    end
    for (int i = 0; i < HI - LO; i++) begin
      step(0, 0, 1, 8'h52);
      chk("R4", "write each cycle", int'(iss_valid && iss_write), 1);
      chk("R8", "fifo order", int'(iss_data), 8'hA0 + i);
      chk("R5", "occupancy in drain", int'(occupancy), HI - i);
    end
    for (int k = 0; k < TURN; k++) begin
      step(0, 0, 1, 8'h52);
      chk("R7", "idle back to read", int'(iss_valid), 0);
    end
    chk("R5", "stops at low mark", int'(occupancy), LO);
    step(0, 0, 1, 8'h52);
    chk("R5", "reads resume", int'(rd_ready), 1);
  endtask

  task automatic t_full();
    int sent = 0;
    do_reset();
    for (int s = 0; s < HI + TURN; s++) begin
      step(1, sent, 1, 8'h60);
      if (wr_ready) sent++;
    end
    chk("R10", "occupancy at top", int'(occupancy), DEPTH);
    chk("R10", "wr_ready low when full", int'(wr_ready), 0);
    chk("R10", "accepted count", sent, DEPTH);
    for (int i = 0; i < DEPTH - LO; i++) begin
      step(0, 0, 1, 8'h61);
      chk("R8", "write order", int'(iss_valid && iss_write ? iss_data : 8'hFF), i);
    end
    step(0, 0, 1, 8'h61);
    chk("R10", "refused write not stored", int'(occupancy), LO);
    chk("R5", "drain ended", int'(iss_valid), 0);
  endtask

  initial begin
    t_reset();
    t_reads();
    t_opportunistic();
    t_drain();
    t_full();
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    #2000000;
    fails++;
    $display("FAIL watchdog expired actual=0 expected=1");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule